// File: doc/BRIEF.md
# Word Shifter with Out-of-Range Amount Handling

This block is a purely combinational 32-bit shifter for an integer execution pipe. It performs logical left shifts, logical right shifts and sign-filling (algebraic) right shifts. The shift distance comes from one of two places. The register forms take it from a six-bit field: the low six bits of a register operand. The immediate form takes it from a five-bit field of the instruction. The amount is never reduced modulo the word width. A register amount of 32 to 63 drains the word completely.

Along with the shifted word, the block returns three more things. It gives a carry flag and a carry-valid strobe for the algebraic forms. It gives a four-bit condition field built from the result, together with a write enable that follows the record flag. The pipe writes these into its own flag registers. The block has no clock and no state. Its only internal decode is the operation select, which is an enumeration with four named operations: OP_SHL, OP_SHR, OP_SAR and OP_SARI. Each operation is a fixed combinational path, so the block has no transitions between operations. Results are valid in the same cycle as the inputs.

Top module: `word_shifter`

## Requirements
- R1: `op_sel` encodes the operation as follows: 2'b00 is a logical left shift, 2'b01 is a logical right shift, 2'b10 is an algebraic right shift with a register amount, and 2'b11 is an algebraic right shift with an immediate amount.
- R2: Operations 00, 01 and 10 take their amount from all six bits of `reg_amt`. Operation 11 takes its amount from `imm_amt`, extended with a zero at the top, and `reg_amt` has no effect on it.
- R3: For both logical forms, an amount whose bit 5 is set (32 to 63) gives a result of zero. The amount is not taken modulo 32.
- R4: For the algebraic forms, an amount of 32 or more gives all ones when `src_word[31]` is 1 and zero otherwise.
- R5: An amount of zero returns `src_word` unchanged, and `ca_out` is 0.
- R6: For amounts from 1 to 31, a logical left shift fills the vacated low bits with zeros, and a logical right shift fills the vacated high bits with zeros.
- R7: For amounts from 1 to 31, an algebraic right shift fills the vacated high bits with copies of `src_word[31]`.
- R8: `ca_valid` is 1 exactly for operations 10 and 11. `ca_out` is 1 only when three conditions all hold: the operation is algebraic, `src_word[31]` is 1, and at least one 1 bit is shifted out below bit 0. For logical operations `ca_out` is 0.
- R9: `cr0_we` equals `rec_en`. In `cr0_val`, bit 3 is "result negative", bit 2 is "result positive and nonzero", bit 1 is "result zero", and bit 0 is a copy of `so_in`. Exactly one of bits 3 to 1 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_word | input | 32 | Word to be shifted |
| reg_amt | input | 6 | Shift amount from the low six bits of a register |
| imm_amt | input | 5 | Shift amount from the instruction immediate |
| op_sel | input | 2 | Operation select (see R1) |
| rec_en | input | 1 | Record flag: request a condition field update |
| so_in | input | 1 | Current summary-overflow bit, copied into the condition field |
| result | output | 32 | Shifted word |
| ca_out | output | 1 | Carry out for the algebraic forms |
| ca_valid | output | 1 | High when `ca_out` should be written |
| cr0_we | output | 1 | Condition field 0 write enable |
| cr0_val | output | 4 | New condition field value: negative, positive, zero, summary overflow |

## Verification
The block has no state. A wrong internal decision therefore shows at the ports in the same evaluation, with no delay:
- A mis-decoded operation shows as a wrong fill direction or a wrong fill value.
- A wrong amount source shows as a dependence of the immediate form on `reg_amt`.
- A wrongly formed loss mask shows as a carry that appears on a positive source, or that goes missing when the only set bit shifted out is bit 0 or bit 30.

The directed sweeps cover every amount from 0 to 63 on every operation, and each vector compares all outputs at once. The 31/32 boundary and the zero amount are exercised on purpose.

// File: rtl/word_shifter_pkg.sv
package word_shifter_pkg;

    localparam int WORD_W = 32;
    localparam int AMT_W  = $clog2(WORD_W) + 1;
    localparam int IMM_W  = $clog2(WORD_W);
    localparam int CRF_W  = 4;

    typedef enum logic [1:0] {
        OP_SHL  = 2'b00,
        OP_SHR  = 2'b01,
        OP_SAR  = 2'b10,
        OP_SARI = 2'b11
    } shop_e;

    typedef struct packed {
        logic go_left;
        logic arith;
        logic use_imm;
    } shctl_t;

endpackage

// File: rtl/shift_amount_sel.sv
module shift_amount_sel
    import word_shifter_pkg::*;
#(
    parameter int AW = AMT_W,
    parameter int IW = IMM_W
) (
    input  shop_e         op,
    input  logic [AW-1:0] reg_amt,
    input  logic [IW-1:0] imm_amt,
    output shctl_t        ctl,
    output logic [AW-1:0] amt
);
    localparam int PAD = AW - IW;

    always_comb begin
        ctl = '0;
        unique case (op)
            OP_SHL:  ctl = '{go_left: 1'b1, arith: 1'b0, use_imm: 1'b0};
            OP_SHR:  ctl = '{go_left: 1'b0, arith: 1'b0, use_imm: 1'b0};
            OP_SAR:  ctl = '{go_left: 1'b0, arith: 1'b1, use_imm: 1'b0};
            OP_SARI: ctl = '{go_left: 1'b0, arith: 1'b1, use_imm: 1'b1};
            default: ctl = '0;
        endcase
    end

    assign amt = ctl.use_imm ? {{PAD{1'b0}}, imm_amt} : reg_amt;

    always_comb begin
        if (op == OP_SARI)
            AST_IMM_IN_RANGE: assert (amt[AW-1] == 1'b0); // R2
    end
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
    import word_shifter_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = AMT_W
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          go_left,
    input  logic          arith,
    output logic [W-1:0]  dout
);
    localparam int STAGES = AW - 1;

    logic         fill;
    logic [W-1:0] flip_in;
    logic [W-1:0] flip_out;
    logic [W-1:0] core_in;
    logic [W-1:0] stage [STAGES+1];

    assign fill = arith & din[W-1];

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_rev_in
            assign flip_in[gi] = din[W-1-gi];
        end
    endgenerate

    assign core_in  = go_left ? flip_in : din;
    assign stage[0] = core_in;

    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            localparam int SH = 1 << gi;
            assign stage[gi+1] = amt[gi] ? {{SH{fill}}, stage[gi][W-1:SH]} : stage[gi];
        end
    endgenerate

    logic [W-1:0] core_out;
    assign core_out = amt[AW-1] ? {W{fill}} : stage[STAGES];

    generate
        for (gi = 0; gi < W; gi++) begin : g_rev_out
            assign flip_out[gi] = core_out[W-1-gi];
        end
    endgenerate

    assign dout = go_left ? flip_out : core_out;

    always_comb begin
        if (amt[AW-1] && !arith)
            AST_WIDE_LOGICAL_ZERO: assert (dout == '0); // R3
        if (amt == '0)
            AST_ZERO_PASS: assert (dout == din); // R5
        if (arith && din[W-1] && amt != '0)
            AST_SIGN_TOP: assert (dout[W-1] == 1'b1); // R7
    end
endmodule

// File: rtl/shift_carry.sv
module shift_carry
    import word_shifter_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = AMT_W
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          arith,
    output logic          ca,
    output logic          ca_we
);
    logic [W-1:0] lost_mask;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_mask
            assign lost_mask[gi] = (AW'(gi) < amt);
        end
    endgenerate

    assign ca    = arith & din[W-1] & (|(din & lost_mask));
    assign ca_we = arith;

    always_comb begin
        if (ca)
            AST_CA_NEEDS_NEG: assert (din[W-1] && arith); // R8
        if (amt == '0)
            AST_CA_ZERO_AMT: assert (!ca); // R5
    end
endmodule

// File: rtl/shift_crfield.sv
module shift_crfield
    import word_shifter_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0]     res,
    input  logic             rec,
    input  logic             so,
    output logic             we,
    output logic [CRF_W-1:0] field
);
    logic is_zero;
    logic is_neg;

    assign is_zero = ~|res;
    assign is_neg  = res[W-1];

    assign we    = rec;
    assign field = {is_neg, ~is_neg & ~is_zero, is_zero, so};

    always_comb begin
        AST_CR_ONE_HOT: assert ($onehot(field[CRF_W-1:1])); // R9
    end
endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import word_shifter_pkg::*;
(
    input  logic [31:0] src_word,
    input  logic [5:0]  reg_amt,
    input  logic [4:0]  imm_amt,
    input  logic [1:0]  op_sel,
    input  logic        rec_en,
    input  logic        so_in,
    output logic [31:0] result,
    output logic        ca_out,
    output logic        ca_valid,
    output logic        cr0_we,
    output logic [3:0]  cr0_val
);
    shop_e             op;
    shctl_t            ctl;
    logic [AMT_W-1:0]  amt;

    assign op = shop_e'(op_sel);

    shift_amount_sel #(.AW(AMT_W), .IW(IMM_W)) u_amt (
        .op      (op),
        .reg_amt (reg_amt),
        .imm_amt (imm_amt),
        .ctl     (ctl),
        .amt     (amt)
    );

    shift_barrel #(.W(WORD_W), .AW(AMT_W)) u_barrel (
        .din     (src_word),
        .amt     (amt),
        .go_left (ctl.go_left),
        .arith   (ctl.arith),
        .dout    (result)
    );

    shift_carry #(.W(WORD_W), .AW(AMT_W)) u_carry (
        .din   (src_word),
        .amt   (amt),
        .arith (ctl.arith),
        .ca    (ca_out),
        .ca_we (ca_valid)
    );

    shift_crfield #(.W(WORD_W)) u_cr (
        .res   (result),
        .rec   (rec_en),
        .so    (so_in),
        .we    (cr0_we),
        .field (cr0_val)
    );

    always_comb begin
        if (!ctl.arith)
            AST_LOGICAL_NO_CA: assert (!ca_out && !ca_valid); // R8
        if (op_sel[1] && amt[5])
            AST_WIDE_SIGN_FILL: assert (result == {32{src_word[31]}}); // R4
    end
endmodule

// File: tb/word_shifter_bench.sv
module word_shifter_bench;

    logic        clk = 1'b0;
    logic [31:0] src_word = '0;
    logic [5:0]  reg_amt = '0;
    logic [4:0]  imm_amt = '0;
    logic [1:0]  op_sel = '0;
    logic        rec_en = 1'b0;
    logic        so_in = 1'b0;
    logic [31:0] result;
    logic        ca_out;
    logic        ca_valid;
    logic        cr0_we;
    logic [3:0]  cr0_val;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    word_shifter u_word_shifter (
        .src_word (src_word),
        .reg_amt  (reg_amt),
        .imm_amt  (imm_amt),
        .op_sel   (op_sel),
        .rec_en   (rec_en),
        .so_in    (so_in),
        .result   (result),
        .ca_out   (ca_out),
        .ca_valid (ca_valid),
        .cr0_we   (cr0_we),
        .cr0_val  (cr0_val)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (op=%0d src=%h ramt=%0d iamt=%0d)",
                     tag, got, exp, op_sel, src_word, reg_amt, imm_amt);
        end
    endtask

    // Reference model built from the requirements
    task automatic apply_check(input logic [1:0] op, input logic [31:0] s,
                               input logic [5:0] ra, input logic [4:0] ia,
                               input logic rec, input logic so, input string tag);
        int amount;
        logic [31:0] e_res;
        logic        lost;
        logic        e_ca;
        logic [3:0]  e_cr;
        @(negedge clk);
        op_sel = op; src_word = s; reg_amt = ra; imm_amt = ia; rec_en = rec; so_in = so;
        #2;
        amount = (op == 2'b11) ? int'(ia) : int'(ra);
        if (op == 2'b00)       e_res = (amount >= 32) ? 32'h0 : (s << amount);
        else if (op == 2'b01)  e_res = (amount >= 32) ? 32'h0 : (s >> amount);
        else                   e_res = (amount >= 32) ? {32{s[31]}} : 32'($signed(s) >>> amount);
        lost = 1'b0;
        for (int i = 0; i < 32; i++) if (i < amount && s[i]) lost = 1'b1;
        e_ca = op[1] && s[31] && lost;
        e_cr = {e_res[31], !e_res[31] && e_res != 0, e_res == 0, so};
        chk({tag, " result"}, result, e_res);
        chk("R8 carry", {31'b0, ca_out}, {31'b0, e_ca});
        chk("R8 carry valid", {31'b0, ca_valid}, {31'b0, op[1]});
        chk("R9 cr write", {31'b0, cr0_we}, {31'b0, rec});
        chk("R9 cr field", {28'b0, cr0_val}, {28'b0, e_cr});
    endtask

    task automatic t_idle;
        #2;
        chk("R5 idle result", result, 32'h0);
        chk("R9 idle field", {28'b0, cr0_val}, 32'h2);
    endtask

    task automatic t_known_values;
        apply_check(2'b00, 32'h0000_00F1, 6'd4, 5'd0, 1'b0, 1'b0, "R6 left");
        chk("R6 left literal", result, 32'h0000_0F10);
        apply_check(2'b01, 32'h8000_0000, 6'd31, 5'd0, 1'b0, 1'b0, "R6 right");
        chk("R6 right literal", result, 32'h0000_0001);
        apply_check(2'b10, 32'h8000_0000, 6'd4, 5'd0, 1'b0, 1'b0, "R7 sar");
        chk("R7 sar literal", result, 32'hF800_0000);
        chk("R8 no lost ones", {31'b0, ca_out}, 32'h0);
    endtask

    task automatic t_wide;
        apply_check(2'b00, 32'hFFFF_FFFF, 6'd32, 5'd0, 1'b1, 1'b0, "R3 left 32");
        chk("R3 left 32 literal", result, 32'h0);
        apply_check(2'b01, 32'hFFFF_FFFF, 6'd63, 5'd0, 1'b0, 1'b0, "R3 right 63");
        apply_check(2'b01, 32'h8000_0001, 6'd33, 5'd0, 1'b0, 1'b0, "R3 no modulo");
        chk("R3 not modulo literal", result, 32'h0);
        apply_check(2'b10, 32'h8000_0000, 6'd40, 5'd0, 1'b1, 1'b1, "R4 neg fill");
        chk("R4 neg fill literal", result, 32'hFFFF_FFFF);
        chk("R8 wide neg carry", {31'b0, ca_out}, 32'h1);
        apply_check(2'b10, 32'h7FFF_FFFF, 6'd32, 5'd0, 1'b1, 1'b0, "R4 pos zero");
        chk("R4 pos literal", result, 32'h0);
    endtask

    task automatic t_zero_amount;
        apply_check(2'b10, 32'h8000_0001, 6'd0, 5'd0, 1'b0, 1'b0, "R5 sar zero");
        chk("R5 pass literal", result, 32'h8000_0001);
        chk("R5 carry clear", {31'b0, ca_out}, 32'h0);
        apply_check(2'b00, 32'hA5A5_5A5A, 6'd0, 5'd0, 1'b0, 1'b0, "R5 shl zero");
    endtask

    task automatic t_immediate;
        apply_check(2'b11, 32'h8000_0010, 6'd63, 5'd4, 1'b0, 1'b0, "R2 imm ignores reg");
        chk("R2 imm literal", result, 32'hF800_0001);
        apply_check(2'b11, 32'hF000_0000, 6'd0, 5'd31, 1'b0, 1'b0, "R2 imm 31");
        chk("R2 imm 31 literal", result, 32'hFFFF_FFFF);
    endtask

    task automatic t_carry_edges;
        apply_check(2'b10, 32'h8000_0001, 6'd1, 5'd0, 1'b0, 1'b0, "R8 bit0 lost");
        chk("R8 bit0 carry", {31'b0, ca_out}, 32'h1);
        apply_check(2'b10, 32'h4000_0001, 6'd1, 5'd0, 1'b0, 1'b0, "R8 positive");
        chk("R8 positive no carry", {31'b0, ca_out}, 32'h0);
        apply_check(2'b01, 32'hFFFF_FFFF, 6'd5, 5'd0, 1'b0, 1'b0, "R8 logical");
        chk("R8 logical no carry", {31'b0, ca_out}, 32'h0);
        apply_check(2'b10, 32'hC000_0000, 6'd31, 5'd0, 1'b0, 1'b0, "R8 bit30 lost");
        chk("R8 bit30 carry", {31'b0, ca_out}, 32'h1);
    endtask

    task automatic t_sweep;
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hDEAD_BEEF; pats[3] = 32'h0123_4567;
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 64; a++)
                for (int p = 0; p < 4; p++)
                    apply_check(op[1:0], pats[p], a[5:0], a[4:0], a[0], a[1], "R1 sweep");
    endtask

    initial begin
        fork
            begin
                t_idle();
                t_known_values();
                t_wide();
                t_zero_amount();
                t_immediate();
                t_carry_edges();
                t_sweep();
                done = 1'b1;
            end
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    n_vec++;
                    n_bad++;
                    $display("FAIL watchdog: got timeout expected completion");
                end
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule